// File: doc/BRIEF.md
# Supply Supervisor With Startup Lockout

This block decides when a switching converter's controller is allowed to drive its power switch. It watches four digitized comparator flags: the supply has risen above the start threshold, the supply has gone over the over-voltage limit (set about 1 V above the start threshold), the supply has dropped under the under-voltage limit, and the current-sense pin has been pulled above its shutdown level. From these flags it produces a switching-enable output and a power-on reset for the downstream control logic. The threshold voltages and the analog comparators sit outside this block.

Start-up uses hysteresis. After an under-voltage event the block stays off until the supply climbs past the full start threshold again. Sagging below the start threshold but staying above the under-voltage limit does not stop a running converter. An over-voltage event latches a fault. The fault clears only after the supply collapses below the under-voltage limit and then rises to the start threshold again. The current-sense shutdown acts as an external kill input: it blanks the enable only while it is asserted and leaves the regulation state untouched.

All pins are plain control signals. No data stream passes through the block, so it has no valid/ready handshake and exerts no back-pressure.

Top module: `supply_supervisor`

## Requirements
- R1: While `rst_n` is low and right after it is released, `sw_en` is 0 and `ctl_reset` is 1.
- R2: When the start flag is raised, `ctl_reset` stays 1 for exactly POR_CYCLES (default 16) clocks after the supervisor accepts the start, then falls, and `sw_en` rises with it. With the defaults, a start flag driven between two edges shows `ctl_reset` low after the 23rd rising edge (2 sync + 4 filter + 1 state + 16 reset) and not after the 22nd.
- R3: Each flag passes through a 2-flop synchronizer and a filter that accepts a new level only after FILT_LEN (default 4) consecutive equal synchronized samples. A pulse shorter than 4 clocks on any flag changes nothing. A pulse of 4 or more clocks is accepted.
- R4: While running, the start flag falling with the under-voltage flag still low keeps `sw_en` at 1.
- R5: An accepted under-voltage flag forces `sw_en` to 0 and `ctl_reset` to 1. Switching resumes only after the start flag is seen again, followed by a new reset period.
- R6: An accepted over-voltage flag forces `sw_en` to 0 and `ctl_reset` to 1 in a latched fault. The fault ignores the over-voltage flag clearing and ignores the start flag. It leaves only once an under-voltage flag is accepted, and a fresh start then restarts the block.
- R7: An accepted current-sense shutdown flag forces `sw_en` to 0 while it lasts. With the defaults, `sw_en` changes after the 6th rising edge following the raw flag change. On release, `sw_en` returns without `ctl_reset` being asserted again.
- R8: A current-sense shutdown during the reset period does not stop or restart the reset countdown. `ctl_reset` still falls at the R2 time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_raw | input | 1 | Supply above start threshold (asynchronous) |
| ovp_raw | input | 1 | Supply above over-voltage limit (asynchronous) |
| uvp_raw | input | 1 | Supply below under-voltage limit (asynchronous) |
| isd_raw | input | 1 | Current-sense pin above shutdown level (asynchronous) |
| sw_en | output | 1 | Gate switching allowed |
| ctl_reset | output | 1 | Reset for the control logic, active high |

## Verification
The hardest condition to reach from the pins is the latched fault being left in the right way. The bench has to drive over-voltage, then take the over-voltage flag away while the start flag remains high, and confirm that nothing restarts. It then has to bring the supply through under-voltage and back to start. Directed sequences walk this path explicitly. Random supply levels, each held long enough for the filters and the reset period to settle, then reach the same exits from every other state. Short glitch pulses, and a shutdown raised during the reset countdown, cover the filter and timer corners.

// File: rtl/sup_pkg.sv
package sup_pkg;

  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_RESET = 2'd1,
    ST_RUN   = 2'd2,
    ST_FAULT = 2'd3
  } sup_state_e;

  localparam int N_FLAGS  = 4;
  localparam int FL_START = 0;
  localparam int FL_OVP   = 1;
  localparam int FL_UVP   = 2;
  localparam int FL_ISD   = 3;

endpackage

// File: rtl/sup_flag_filter.sv
module sup_flag_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic filt_o
);
  localparam int CW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   samp;
  logic [CW-1:0]          cnt_q;
  logic                   filt_q;

  // synchronizer chain
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
  end

  assign samp = sync_q[SYNC_STAGES-1];

  // a new level must persist FILT_LEN samples before it is accepted
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      filt_q <= 1'b0;
    end else if (samp == filt_q) begin
      cnt_q <= '0;
    end else if (cnt_q == CW'(FILT_LEN - 1)) begin
      cnt_q  <= '0;
      filt_q <= samp;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign filt_o = filt_q;

endmodule

// File: rtl/sup_por_timer.sv
module sup_por_timer #(
  parameter int POR_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic done_o
);
  localparam int CW = $clog2(POR_CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load_i)       cnt_q <= CW'(POR_CYCLES - 1);
    else if (cnt_q != '0)  cnt_q <= cnt_q - CW'(1);
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/sup_fsm.sv
module sup_fsm
  import sup_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_f,
  input  logic       ovp_f,
  input  logic       uvp_f,
  input  logic       isd_f,
  input  logic       por_done,
  output logic       por_load,
  output logic       sw_en,
  output logic       ctl_reset,
  output sup_state_e state_o
);
  sup_state_e state_q, state_d;

  always_comb begin
    state_d  = state_q;
    por_load = 1'b0;
    case (state_q)
      ST_OFF: begin
        if (ovp_f) state_d = ST_FAULT;
        else if (start_f && !uvp_f) begin
          state_d  = ST_RESET;
          por_load = 1'b1;
        end
      end
      ST_RESET: begin
        if (ovp_f)         state_d = ST_FAULT;
        else if (uvp_f)    state_d = ST_OFF;
        else if (por_done) state_d = ST_RUN;
      end
      ST_RUN: begin
        if (ovp_f)      state_d = ST_FAULT;
        else if (uvp_f) state_d = ST_OFF;
      end
      ST_FAULT: begin
        if (uvp_f && !ovp_f) state_d = ST_OFF;
      end
      default: state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_OFF;
    else        state_q <= state_d;
  end

  assign ctl_reset = (state_q != ST_RUN);
  assign sw_en     = (state_q == ST_RUN) && !isd_f;
  assign state_o   = state_q;

endmodule

// File: rtl/supply_supervisor.sv
module supply_supervisor
  import sup_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4,
  parameter int POR_CYCLES  = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_raw,
  input  logic ovp_raw,
  input  logic uvp_raw,
  input  logic isd_raw,
  output logic sw_en,
  output logic ctl_reset
);
  logic [N_FLAGS-1:0] raw_vec;
  logic [N_FLAGS-1:0] flt_vec;
  logic               start_f, ovp_f, uvp_f, isd_f;
  logic               por_load, por_done;
  sup_state_e         state;

  always_comb begin
    raw_vec           = '0;
    raw_vec[FL_START] = start_raw;
    raw_vec[FL_OVP]   = ovp_raw;
    raw_vec[FL_UVP]   = uvp_raw;
    raw_vec[FL_ISD]   = isd_raw;
  end

  for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
    sup_flag_filter #(
      .SYNC_STAGES (SYNC_STAGES),
      .FILT_LEN    (FILT_LEN)
    ) u_filt (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  (raw_vec[g]),
      .filt_o (flt_vec[g])
    );
  end

  assign start_f = flt_vec[FL_START];
  assign ovp_f   = flt_vec[FL_OVP];
  assign uvp_f   = flt_vec[FL_UVP];
  assign isd_f   = flt_vec[FL_ISD];

  sup_por_timer #(.POR_CYCLES(POR_CYCLES)) u_por (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (por_load),
    .done_o (por_done)
  );

  sup_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_f   (start_f),
    .ovp_f     (ovp_f),
    .uvp_f     (uvp_f),
    .isd_f     (isd_f),
    .por_done  (por_done),
    .por_load  (por_load),
    .sw_en     (sw_en),
    .ctl_reset (ctl_reset),
    .state_o   (state)
  );

endmodule

// File: rtl/sup_checker.sv
module sup_checker
  import sup_pkg::*;
#(
  parameter int POR_CYCLES = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       sw_en,
  input logic       ctl_reset,
  input logic       ovp_f,
  input logic       uvp_f,
  input logic       isd_f,
  input sup_state_e state
);
  logic [15:0] hi_len;

  // length of the current run of ctl_reset high, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                hi_len <= '0;
    else if (!ctl_reset)       hi_len <= '0;
    else if (hi_len != 16'hFFFF) hi_len <= hi_len + 16'd1;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_outputs: assert (ctl_reset && !sw_en)
        else $error("R1: outputs wrong during reset");
    end
  end

  a_r2_por_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl_reset) |-> (hi_len >= 16'(POR_CYCLES)));

  a_r2_enable_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    sw_en |-> !ctl_reset);

  a_r5_uv_stops: assert property (@(posedge clk) disable iff (!rst_n)
    uvp_f |=> !sw_en);

  a_r6_ov_faults: assert property (@(posedge clk) disable iff (!rst_n)
    ovp_f |=> (!sw_en && state == ST_FAULT));

  a_r6_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FAULT && !uvp_f) |=> (state == ST_FAULT));

  a_r7_isd_masks: assert property (@(posedge clk) disable iff (!rst_n)
    isd_f |-> !sw_en);

  a_r7_isd_keeps_run: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && !uvp_f && !ovp_f) |=> (state == ST_RUN));

endmodule

bind supply_supervisor sup_checker #(.POR_CYCLES(POR_CYCLES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sw_en     (sw_en),
  .ctl_reset (ctl_reset),
  .ovp_f     (ovp_f),
  .uvp_f     (uvp_f),
  .isd_f     (isd_f),
  .state     (state)
);

// File: tb/test_supply_supervisor.sv
module test_supply_supervisor;
  localparam int SYNC  = 2;
  localparam int FILT  = 4;
  localparam int POR   = 16;
  localparam int LAT_F = SYNC + FILT;          // edges until a filtered flag flips
  localparam int LAT_S = LAT_F + 1 + POR;      // edges from start flag to release
  localparam int HOLD  = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_raw = 1'b0, ovp_raw = 1'b0, uvp_raw = 1'b0, isd_raw = 1'b0;
  logic sw_en, ctl_reset;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // model modes: 0 off, 1 run, 2 fault ; levels: 0 low, 1 mid, 2 start, 3 over
  int mode = 0;

  always #10 clk = ~clk;

  supply_supervisor #(.SYNC_STAGES(SYNC), .FILT_LEN(FILT), .POR_CYCLES(POR)) i_supply_supervisor (
    .clk(clk), .rst_n(rst_n), .start_raw(start_raw), .ovp_raw(ovp_raw),
    .uvp_raw(uvp_raw), .isd_raw(isd_raw), .sw_en(sw_en), .ctl_reset(ctl_reset)
  );

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic set_level(int lvl);
    start_raw = (lvl >= 2);
    ovp_raw   = (lvl == 3);
    uvp_raw   = (lvl == 0);
  endtask

  function automatic int next_mode(int m, int lvl);
    if (lvl == 3) return 2;
    case (m)
      0: return (lvl == 2) ? 1 : 0;
      1: return (lvl == 0) ? 0 : 1;
      default: return (lvl == 0) ? 0 : 2;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int bad;
    void'($urandom(32'h5eed_0042));
    step(3);
    chk("R1", "sw_en in reset", sw_en, 1'b0);
    chk("R1", "ctl_reset in reset", ctl_reset, 1'b1);
    rst_n = 1'b1;
    step(2);
    chk("R1", "sw_en after reset", sw_en, 1'b0);
    chk("R1", "ctl_reset after reset", ctl_reset, 1'b1);

    // R2 exact start latency
    set_level(1); step(10);
    set_level(2);
    step(LAT_S - 1);
    chk("R2", "ctl_reset one edge early", ctl_reset, 1'b1);
    step(1);
    chk("R2", "ctl_reset released", ctl_reset, 1'b0);
    chk("R2", "sw_en released", sw_en, 1'b1);

    // R3 short pulse on shutdown and under-voltage flags ignored
    bad = 0;
    isd_raw = 1'b1; step(FILT - 1); isd_raw = 1'b0;
    for (int i = 0; i < 12; i++) begin step(1); if (sw_en !== 1'b1) bad++; end
    uvp_raw = 1'b1; step(FILT - 1); uvp_raw = 1'b0;
    for (int i = 0; i < 12; i++) begin step(1); if (sw_en !== 1'b1) bad++; end
    chk("R3", "sw_en kept through short glitches", bad == 0, 1'b1);

    // R7 shutdown latency and release without new reset (also R3 long pulse)
    isd_raw = 1'b1;
    step(LAT_F - 1);
    chk("R7", "sw_en before shutdown accepted", sw_en, 1'b1);
    step(1);
    chk("R7", "sw_en masked", sw_en, 1'b0);
    chk("R7", "ctl_reset stays low in shutdown", ctl_reset, 1'b0);
    step(10);
    isd_raw = 1'b0;
    step(LAT_F - 1);
    chk("R7", "sw_en still masked", sw_en, 1'b0);
    step(1);
    chk("R7", "sw_en back", sw_en, 1'b1);
    chk("R7", "no new reset", ctl_reset, 1'b0);

    // R4 hysteresis
    set_level(1); step(HOLD);
    chk("R4", "run below start", sw_en, 1'b1);

    // R5 under-voltage and restart
    set_level(0); step(12);
    chk("R5", "sw_en off after uv", sw_en, 1'b0);
    chk("R5", "ctl_reset after uv", ctl_reset, 1'b1);
    set_level(1); step(HOLD);
    chk("R5", "no restart without start", sw_en, 1'b0);
    set_level(2); step(HOLD);
    chk("R5", "restart after start", sw_en, 1'b1);

    // R6 latched fault
    set_level(3); step(12);
    chk("R6", "sw_en off in fault", sw_en, 1'b0);
    chk("R6", "ctl_reset in fault", ctl_reset, 1'b1);
    set_level(2); step(HOLD);
    chk("R6", "fault holds with start high", sw_en, 1'b0);
    set_level(1); step(HOLD);
    chk("R6", "fault holds at mid level", ctl_reset, 1'b1);
    set_level(0); step(12);
    set_level(2); step(HOLD);
    chk("R6", "restart after uv then start", sw_en, 1'b1);

    // R8 shutdown during reset countdown
    set_level(0); step(12);
    set_level(2); isd_raw = 1'b1;
    step(LAT_S - 1);
    chk("R8", "ctl_reset before end of countdown", ctl_reset, 1'b1);
    step(1);
    chk("R8", "countdown not disturbed", ctl_reset, 1'b0);
    chk("R8", "sw_en masked while shutdown", sw_en, 1'b0);
    isd_raw = 1'b0; step(LAT_F);
    chk("R8", "sw_en after shutdown release", sw_en, 1'b1);

    // random levels against the bench model
    set_level(0); isd_raw = 1'b0; step(HOLD); mode = 0;
    for (int it = 0; it < 80; it++) begin
      int lvl;
      logic isd;
      lvl = int'($urandom_range(3));
      isd = ($urandom_range(3) == 0);
      set_level(lvl); isd_raw = isd;
      step(HOLD);
      mode = next_mode(mode, lvl);
      case (lvl)
        0: chk("R5", "random sw_en", sw_en, (mode == 1) && !isd);
        3: chk("R6", "random sw_en", sw_en, (mode == 1) && !isd);
        default: chk("R7", "random sw_en", sw_en, (mode == 1) && !isd);
      endcase
      chk("R2", "random ctl_reset", ctl_reset, mode != 1);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule